// File: doc/BRIEF.md
# Single-Level Page Translator With Reference Tracking

This block converts a 16-bit virtual address into a 16-bit physical address using a page table of 16 entries held in flip-flops. Each page is 4096 bytes. The upper four address bits select an entry. The entry's 4-bit frame number replaces them, and the low 12 bits pass through unchanged. Each entry also carries a valid flag and a reference flag. Every successful lookup raises the reference flag of the entry it used. A single strobe drops all reference flags together, so an outside agent can sample which pages were touched during an interval.

Software or a controller fills the table through a one-entry-per-cycle load port. Loading an entry sets its frame and valid flag and clears its reference flag. The reference flags are always visible on a 16-bit read-back bus.

Lookups are registered. A small response state machine records the outcome of the request from the previous cycle:
- `OS_IDLE`: there is no response.
- `OS_HIT`: a valid translation is on the output.
- `OS_FAULT`: the entry was invalid.

The next state follows only the current request:
- No request goes to `OS_IDLE`.
- A request to a valid entry goes to `OS_HIT`.
- A request to an invalid entry goes to `OS_FAULT`.

These transitions apply from every state.

Top module: `page_xlate_top`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and all of `ref_bits` are 0, and every entry is invalid, so any first lookup faults.
- R2: A request to a valid entry gives `rsp_paddr = {frame, lk_vaddr[11:0]}`, with `rsp_valid=1` and `rsp_fault=0`, in the cycle after the request. The frame is the one held by entry `lk_vaddr[15:12]`.
- R3: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_req=1`, and 0 after a cycle without a request.
- R4: A request to an invalid entry gives `rsp_valid=1`, `rsp_fault=1` and `rsp_paddr=0` in the next cycle, and leaves that entry's reference flag unchanged.
- R5: A successful lookup of entry i makes `ref_bits[i]` 1 from the next cycle on. Bit i of `ref_bits` belongs to entry i.
- R6: A cycle with `ref_clr=1` makes every `ref_bits` position 0 in the next cycle.
- R7: When `ref_clr` and a successful lookup occur in the same cycle, the looked-up entry's flag is 1 afterwards and all other flags are 0.
- R8: A cycle with `wr_en=1` stores `wr_frame` and `wr_valid` into entry `wr_idx` and clears that entry's reference flag. A lookup in the same cycle uses the entry's previous contents.
- R9: With entry 14 = frame 3, entry 3 = frame 10, entry 10 = frame 5 and entry 7 = frame 15, the translator gives these results: 0xE12C→0x312C, 0x3A9D→0xAA9D, 0xA9D9→0x59D9, 0x7001→0xF001 and 0xACA1→0x5CA1.
- R10: Loading an entry with `wr_valid=0` makes later lookups of it fault.
- R11: When a write and a successful lookup of the same entry occur in the same cycle, that entry's reference flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response present (from the previous cycle's request) |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| wr_en | input | 1 | Load one table entry |
| wr_idx | input | 4 | Entry to load |
| wr_frame | input | 4 | Frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| ref_clr | input | 1 | Clear all reference flags |
| ref_bits | output | 16 | Reference flag of each entry |

## Verification
Every result of this block is due one clock edge after its cause. This covers the response to a lookup, a reference flag raised by a hit, the bulk clear and a loaded entry. The bench therefore drives each stimulus on a falling edge and checks on the following falling edge, one full rising edge later. The same-cycle conflicts are driven in a single cycle and checked on the next falling edge: clear against hit, and write against lookup of the same entry. Sampling there shows which action prevailed.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
    localparam int VA_W_DEF  = 16;
    localparam int PA_W_DEF  = 16;
    localparam int OFF_W_DEF = 12;

    typedef enum logic [1:0] {
        OS_IDLE  = 2'd0,
        OS_HIT   = 2'd1,
        OS_FAULT = 2'd2
    } out_state_e;
endpackage

// File: rtl/pxl_table.sv
module pxl_table #(
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid
);
    logic [FRAME_W-1:0] frame_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_q[e] <= '0;
                valid_q[e] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                frame_q[e] <= wr_frame;
                valid_q[e] <= wr_valid;
            end
        end
    end

    always_comb begin
        rd_frame = frame_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end

    // R8: a load is visible in the entry on the next cycle
    a_r8_load_stores: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] == $past(wr_valid))
               && (frame_q[$past(wr_idx)] == $past(wr_frame)));
endmodule

// File: rtl/pxl_refbits.sv
module pxl_refbits #(
    parameter int IDX_W = 4,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_all,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    output logic [ENTRIES-1:0] ref_q
);
    logic [ENTRIES-1:0] set_mask;
    logic [ENTRIES-1:0] wclr_mask;

    always_comb begin
        set_mask  = set_en ? (ENTRIES'(1) << set_idx) : '0;
        wclr_mask = wr_en  ? (ENTRIES'(1) << wr_idx)  : '0;
    end

    // per-entry flag: set wins over both clears
    for (genvar e = 0; e < ENTRIES; e++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                ref_q[e] <= 1'b0;
            else if (set_mask[e])
                ref_q[e] <= 1'b1;
            else if (clr_all || wclr_mask[e])
                ref_q[e] <= 1'b0;
        end
    end

    a_r5_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ref_q[$past(set_idx)]);
    a_r6_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !set_en) |=> (ref_q == '0));
    a_r7_clear_vs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && set_en) |=> ($countones(ref_q) == 1) && ref_q[$past(set_idx)]);
    a_r11_write_vs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && set_en && (wr_idx == set_idx)) |=> ref_q[$past(wr_idx)]);
endmodule

// File: rtl/pxl_resp.sv
module pxl_resp
    import pxl_pkg::*;
#(
    parameter int PA_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            hit,
    input  logic [PA_W-1:0] pa_in,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [PA_W-1:0] rsp_paddr
);
    out_state_e      state_q, state_d;
    logic [PA_W-1:0] pa_q;

    always_comb begin
        state_d = OS_IDLE;
        if (req) state_d = hit ? OS_HIT : OS_FAULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            pa_q    <= (req && hit) ? pa_in : '0;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_paddr = '0;
        unique case (state_q)
            OS_IDLE:  ;
            OS_HIT: begin
                rsp_valid = 1'b1;
                rsp_paddr = pa_q;
            end
            OS_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
            end
            default: ;
        endcase
    end

    a_r3_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);
    a_r3_idle_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);
    a_r4_fault_only_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import pxl_pkg::*;
#(
    parameter int VA_W  = VA_W_DEF,
    parameter int PA_W  = PA_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    localparam int IDX_W   = VA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic [VA_W-1:0]    lk_vaddr,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               ref_clr,
    output logic [ENTRIES-1:0] ref_bits
);
    logic [IDX_W-1:0]   lk_idx;
    logic [FRAME_W-1:0] tbl_frame;
    logic               tbl_valid;
    logic               lk_hit;
    logic [PA_W-1:0]    pa_next;

    always_comb begin
        lk_idx  = lk_vaddr[VA_W-1:OFF_W];
        lk_hit  = lk_req && tbl_valid;
        pa_next = {tbl_frame, lk_vaddr[OFF_W-1:0]};
    end

    pxl_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .rd_idx(lk_idx), .rd_frame(tbl_frame), .rd_valid(tbl_valid)
    );

    pxl_refbits #(.IDX_W(IDX_W)) u_ref (
        .clk(clk), .rst_n(rst_n),
        .set_en(lk_hit), .set_idx(lk_idx), .clr_all(ref_clr),
        .wr_en(wr_en), .wr_idx(wr_idx), .ref_q(ref_bits)
    );

    pxl_resp #(.PA_W(PA_W)) u_resp (
        .clk(clk), .rst_n(rst_n),
        .req(lk_req), .hit(tbl_valid), .pa_in(pa_next),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    a_r2_translate: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && tbl_valid) |=> !rsp_fault
            && (rsp_paddr == {$past(tbl_frame), $past(lk_vaddr[OFF_W-1:0])}));
    a_r4_fault_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !tbl_valid && !ref_clr && !(wr_en && wr_idx == lk_idx))
            |=> rsp_fault && (rsp_paddr == '0)
             && (ref_bits[$past(lk_idx)] == $past(ref_bits[lk_idx])));
endmodule

// File: tb/tb_page_xlate_top.sv
module tb_page_xlate_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [15:0] lk_vaddr = '0;
    logic        rsp_valid, rsp_fault;
    logic [15:0] rsp_paddr;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [3:0]  wr_frame = '0;
    logic        wr_valid = 1'b0;
    logic        ref_clr = 1'b0;
    logic [15:0] ref_bits;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    page_xlate_top dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .ref_clr(ref_clr), .ref_bits(ref_bits)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        lk_req = 1'b0; wr_en = 1'b0; ref_clr = 1'b0;
    endtask

    // drive at a falling edge; results checked on the next falling edge
    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] idx, input logic [3:0] fr, input logic v);
        idle_inputs();
        wr_en = 1'b1; wr_idx = idx; wr_frame = fr; wr_valid = v;
        cycle();
        idle_inputs();
    endtask

    task automatic lookup_expect(input string tag, input logic [15:0] va,
                                 input logic fault, input logic [15:0] pa);
        idle_inputs();
        lk_req = 1'b1; lk_vaddr = va;
        cycle();
        idle_inputs();
        chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(fault));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", 32'(rsp_valid), 32'd0);
        chk("R1 fault after reset", 32'(rsp_fault), 32'd0);
        chk("R1 ref_bits after reset", 32'(ref_bits), 32'd0);
        lookup_expect("R1 first lookup faults", 16'h5123, 1'b1, 16'h0000);
        chk("R4 fault leaves ref", 32'(ref_bits), 32'd0);
    endtask

    task automatic t_examples();
        load(4'd14, 4'd3, 1'b1);
        load(4'd3, 4'd10, 1'b1);
        load(4'd10, 4'd5, 1'b1);
        load(4'd7, 4'd15, 1'b1);
        chk("R8 load leaves ref clear", 32'(ref_bits), 32'd0);
        lookup_expect("R9 0xE12C", 16'hE12C, 1'b0, 16'h312C);
        chk("R5 ref bit 14", 32'(ref_bits), 32'h4000);
        lookup_expect("R9 0x3A9D", 16'h3A9D, 1'b0, 16'hAA9D);
        lookup_expect("R9 0xA9D9", 16'hA9D9, 1'b0, 16'h59D9);
        lookup_expect("R2 R9 0x7001", 16'h7001, 1'b0, 16'hF001);
        lookup_expect("R9 0xACA1", 16'hACA1, 1'b0, 16'h5CA1);
        chk("R5 ref bits 14,10,7,3", 32'(ref_bits), 32'h4488);
    endtask

    task automatic t_timing();
        cycle();
        chk("R3 no response without request", 32'(rsp_valid), 32'd0);
        chk("R3 no fault without request", 32'(rsp_fault), 32'd0);
    endtask

    task automatic t_clear();
        idle_inputs(); ref_clr = 1'b1;
        cycle(); idle_inputs();
        chk("R6 bulk clear", 32'(ref_bits), 32'd0);
    endtask

    task automatic t_clear_vs_hit();
        lookup_expect("R5 0x3000", 16'h3000, 1'b0, 16'hA000);
        idle_inputs(); ref_clr = 1'b1; lk_req = 1'b1; lk_vaddr = 16'h7001;
        cycle(); idle_inputs();
        chk("R7 clear and hit", 32'(ref_bits), 32'h0080);
        chk("R7 paddr", 32'(rsp_paddr), 32'hF001);
    endtask

    task automatic t_fault();
        lookup_expect("R4 invalid entry 1", 16'h1234, 1'b1, 16'h0000);
        chk("R4 ref unchanged", 32'(ref_bits), 32'h0080);
    endtask

    task automatic t_write_clears();
        load(4'd7, 4'd2, 1'b1);
        chk("R8 write clears ref", 32'(ref_bits), 32'h0000);
        lookup_expect("R8 new frame", 16'h7ABC, 1'b0, 16'h2ABC);
    endtask

    task automatic t_write_vs_lookup();
        idle_inputs();
        wr_en = 1'b1; wr_idx = 4'd3; wr_frame = 4'd9; wr_valid = 1'b1;
        lk_req = 1'b1; lk_vaddr = 16'h3111;
        cycle(); idle_inputs();
        chk("R8 same-cycle lookup uses old frame", 32'(rsp_paddr), 32'hA111);
        chk("R11 ref stays set", 32'(ref_bits), 32'h0088);
        lookup_expect("R8 new frame after write", 16'h3111, 1'b0, 16'h9111);
    endtask

    task automatic t_invalidate();
        load(4'd10, 4'd5, 1'b0);
        lookup_expect("R10 invalidated entry", 16'hA9D9, 1'b1, 16'h0000);
        chk("R10 no ref set", 32'(ref_bits & 16'h0400), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycle();
        t_reset();
        t_examples();
        t_timing();
        t_clear();
        t_clear_vs_hit();
        t_fault();
        t_write_clears();
        t_write_vs_lookup();
        t_invalidate();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule